// File: doc/BRIEF.md
# UART Software Flow Control Engine

This block sits between a UART's character receiver and transmitter and their FIFOs. It carries out in-band Xon/Xoff flow control, driven by a 4-bit control field. On the receive side it screens every incoming character against four programmed codes: two Xon codes and two Xoff codes. A recognised Xoff pauses the local transmitter, and a recognised Xon resumes it. These control characters are consumed and are never stored as data.

On the transmit side it watches the receive FIFO fill level. When the level reaches a high mark, it inserts the selected Xoff character(s) into the outgoing stream ahead of queued data. When the level later drains to a low mark, it inserts the matching Xon character(s).

With all flow control off, an optional special-character mode passes every byte through unchanged. It raises a sticky status flag whenever a byte equals the second Xoff code. The host clears that flag by reading its interrupt status.

All character traffic uses simple valid/ready ports. The serial shifters, the baud logic and the FIFO storage lie outside the block.

Top module: `swfc_engine`

## Requirements
- R1: After reset, `tx_paused`, `spec_flag`, `rxf_valid` and `txs_valid` are all 0.
- R2: With `cfg_mode[1:0]` = 2'b10 the receiver matches `cfg_xon1`/`cfg_xoff1`, and with 2'b01 it matches `cfg_xon2`/`cfg_xoff2`. Each match is a full equality, bit 0 of the code against bit 0 of the character. A matched Xoff sets `tx_paused` and a matched Xon clears it. Matched characters are dropped. All other characters reach `rxf_*` unchanged and in arrival order.
- R3: With `cfg_mode[1:0]` = 2'b11, a pause needs Xoff1 immediately followed by Xoff2, and a resume needs Xon1 immediately followed by Xon2. Both characters of such a pair are dropped. If the character after Xoff1 or Xon1 is not its partner, the first character is forwarded as data and the second is then judged afresh. A lone second code is forwarded as data.
- R4: With `cfg_mode[1:0]` = 2'b00 every character is forwarded, and `tx_paused` is 0 from the next cycle on.
- R5: While `tx_paused` is 1, `txf_ready` is 0 and no data character leaves toward the shifter. Data flow resumes after the Xon.
- R6: `cfg_mode[3:2]` selects the transmitted codes. 2'b10 sends Xoff1 and Xon1. 2'b01 sends Xoff2 and Xon2. 2'b11 sends the pair Xoff1 then Xoff2, and the pair Xon1 then Xon2. 2'b00 sends none.
- R7: Exactly one Xoff (or Xoff pair) is sent when `rxf_level` reaches `cfg_hi_lvl` or more. Exactly one Xon (or pair) is sent when the level later drops to `cfg_lo_lvl` or less, and only if an Xoff was sent before.
- R8: A pending flow character goes out before the next data character. The Xoff appears no later than the second character accepted by the shifter after the cycle in which the level crosses. Data characters are neither lost nor reordered around inserted codes.
- R9: With `cfg_spec_en` = 1 and `cfg_mode` = 4'b0000, a received character equal to `cfg_xoff2` is forwarded as data, and `spec_flag` is 1 from the cycle after its acceptance.
- R10: Special-character detection is ignored unless `cfg_mode` = 4'b0000. With any other mode, `spec_flag` is not set.
- R11: `spec_flag` stays set until a cycle with `isr_rd` = 1, and is 0 in the cycle after that read.
- R12: `rxf_data` holds while `rxf_valid` is 1 and `rxf_ready` is 0. `txs_data` holds while `txs_valid` is 1 and `txs_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 4 | Flow control field: [3:2] transmit mode, [1:0] receive mode |
| cfg_spec_en | input | 1 | Special-character detect enable |
| cfg_xon1 | input | DW | First Xon code |
| cfg_xon2 | input | DW | Second Xon code |
| cfg_xoff1 | input | DW | First Xoff code |
| cfg_xoff2 | input | DW | Second Xoff code, also the special character |
| cfg_hi_lvl | input | LW | Receive FIFO level that triggers Xoff |
| cfg_lo_lvl | input | LW | Receive FIFO level that triggers Xon |
| rxc_valid | input | 1 | Character from receiver valid |
| rxc_data | input | DW | Character from receiver |
| rxc_ready | output | 1 | Character accepted (may depend on valid and data) |
| rxf_valid | output | 1 | Data character for receive FIFO valid |
| rxf_data | output | DW | Data character for receive FIFO |
| rxf_ready | input | 1 | Receive FIFO can accept |
| rxf_level | input | LW | Current receive FIFO fill level |
| txf_valid | input | 1 | Transmit FIFO has a character |
| txf_data | input | DW | Transmit FIFO head character |
| txf_ready | output | 1 | Character taken from transmit FIFO |
| txs_valid | output | 1 | Character for transmit shifter valid |
| txs_data | output | DW | Character for transmit shifter |
| txs_ready | input | 1 | Transmit shifter accepts |
| isr_rd | input | 1 | Host reads interrupt status; clears `spec_flag` |
| tx_paused | output | 1 | Remote end has paused this transmitter |
| spec_flag | output | 1 | Special character seen |

## Verification
The hardest state to reach from the ports is the combined-set receive mode with a first code already held when a non-partner character arrives. This must release the held byte and re-judge the newcomer in the next cycle. Directed sequences such as Xon1, Xoff1, Xoff2 lead into it and check both the forwarded bytes and the final pause state.

Insertion priority is reached by streaming transmit data every cycle while the FIFO level ramps through every value up to its top and back. The bench then locates each inserted code against the crossing cycle and checks that the surrounding data run has no gaps.

The single-set receive modes and special detect are swept over all 256 character values, upward and downward.

// File: rtl/swfc_pkg.sv
// Shared types for the software flow control engine.
// Assumes: a 2-bit mode half-field, coded as below; bit order is fixed
// because decoding of the field depends on it.
package swfc_pkg;

    typedef enum logic [1:0] {
        FC_NONE = 2'b00,   // no flow characters
        FC_SET2 = 2'b01,   // second Xon/Xoff set only
        FC_SET1 = 2'b10,   // first Xon/Xoff set only
        FC_BOTH = 2'b11    // both sets, used as an ordered pair
    } fc_sel_e;

endpackage

// File: rtl/swfc_rx_filter.sv
// Receive screening: removes Xon/Xoff characters from the data stream,
// keeps the remote pause state, and raises the special-character flag.
// Assumes: a single-entry output register toward the FIFO; in_ready may
// depend on in_valid and in_data (a held pair start that mismatches stalls
// the newcomer for one cycle while the held byte is released).
module swfc_rx_filter
    import swfc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fc_sel_e       rx_sel,
    input  logic          spec_on,
    input  logic [DW-1:0] xon1,
    input  logic [DW-1:0] xon2,
    input  logic [DW-1:0] xoff1,
    input  logic [DW-1:0] xoff2,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          out_ready,
    input  logic          flag_clr,
    output logic          paused,
    output logic          spec_flag
);

    logic          ob_valid;
    logic [DW-1:0] ob_data;
    logic          hold_valid;
    logic          hold_off;
    logic [DW-1:0] hold_data;

    logic          slot_free;
    logic          take, emit, release_h, hold_load, hold_load_off, hold_drop;
    logic          pause_set, pause_clr, spec_hit;
    logic [DW-1:0] partner, s_on, s_off;

    assign slot_free = !ob_valid || out_ready;
    assign partner   = hold_off ? xoff2 : xon2;
    assign s_on      = (rx_sel == FC_SET2) ? xon2  : xon1;
    assign s_off     = (rx_sel == FC_SET2) ? xoff2 : xoff1;

    // Decide what to do with the offered character this cycle.
    always_comb begin
        take          = 1'b0;
        emit          = 1'b0;
        release_h     = 1'b0;
        hold_load     = 1'b0;
        hold_load_off = 1'b0;
        hold_drop     = 1'b0;
        pause_set     = 1'b0;
        pause_clr     = 1'b0;
        spec_hit      = 1'b0;
        if (slot_free) begin
            if (hold_valid) begin
                if (rx_sel != FC_BOTH) begin
                    release_h = 1'b1;
                end else if (in_valid) begin
                    if (in_data == partner) begin
                        take      = 1'b1;
                        hold_drop = 1'b1;
                        pause_set = hold_off;
                        pause_clr = !hold_off;
                    end else begin
                        release_h = 1'b1;
                    end
                end
            end else if (in_valid) begin
                take = 1'b1;
                case (rx_sel)
                    FC_BOTH: begin
                        if (in_data == xoff1) begin
                            hold_load     = 1'b1;
                            hold_load_off = 1'b1;
                        end else if (in_data == xon1) begin
                            hold_load = 1'b1;
                        end else begin
                            emit = 1'b1;
                        end
                    end
                    FC_SET1, FC_SET2: begin
                        if (in_data == s_off)     pause_set = 1'b1;
                        else if (in_data == s_on) pause_clr = 1'b1;
                        else                      emit      = 1'b1;
                    end
                    default: begin
                        emit     = 1'b1;
                        spec_hit = spec_on && (in_data == xoff2);
                    end
                endcase
            end
        end
    end

    assign in_ready  = take;
    assign out_valid = ob_valid;
    assign out_data  = ob_data;

    // Output register toward the receive FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ob_valid <= 1'b0;
            ob_data  <= '0;
        end else if (release_h) begin
            ob_valid <= 1'b1;
            ob_data  <= hold_data;
        end else if (emit) begin
            ob_valid <= 1'b1;
            ob_data  <= in_data;
        end else if (out_ready) begin
            ob_valid <= 1'b0;
        end
    end

    // Holding register for the first code of a pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_off   <= 1'b0;
            hold_data  <= '0;
        end else if (hold_load) begin
            hold_valid <= 1'b1;
            hold_off   <= hold_load_off;
            hold_data  <= in_data;
        end else if (release_h || hold_drop) begin
            hold_valid <= 1'b0;
        end
    end

    // Remote pause state; forced clear when receive screening is off.
    always_ff @(posedge clk) begin
        if (!rst_n)                 paused <= 1'b0;
        else if (rx_sel == FC_NONE) paused <= 1'b0;
        else if (pause_set)         paused <= 1'b1;
        else if (pause_clr)         paused <= 1'b0;
    end

    // Sticky special-character flag; a new hit wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        spec_flag <= 1'b0;
        else if (spec_hit) spec_flag <= 1'b1;
        else if (flag_clr) spec_flag <= 1'b0;
    end

endmodule

// File: rtl/swfc_level_mon.sv
// Watches the receive FIFO level and raises one Xoff request on reaching
// the high mark, then one Xon request on draining to the low mark.
// Assumes: hi > lo; requests are cleared by the transmit side's done pulses.
module swfc_level_mon
    import swfc_pkg::*;
#(
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fc_sel_e       tx_sel,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] hi_lvl,
    input  logic [LW-1:0] lo_lvl,
    input  logic          xoff_done,
    input  logic          xon_done,
    output logic          need_xoff,
    output logic          need_xon
);

    logic armed;

    // Hysteresis: arm on the high mark, disarm on the low mark.
    always_ff @(posedge clk) begin
        if (!rst_n || tx_sel == FC_NONE) begin
            armed     <= 1'b0;
            need_xoff <= 1'b0;
            need_xon  <= 1'b0;
        end else if (!armed && level >= hi_lvl) begin
            armed     <= 1'b1;
            need_xoff <= 1'b1;
            need_xon  <= 1'b0;
        end else if (armed && level <= lo_lvl) begin
            armed     <= 1'b0;
            need_xon  <= 1'b1;
            need_xoff <= 1'b0;
        end else begin
            if (xoff_done) need_xoff <= 1'b0;
            if (xon_done)  need_xon  <= 1'b0;
        end
    end

endmodule

// File: rtl/swfc_tx_arb.sv
// Chooses the next character for the transmit shifter: second code of a
// pair first, then a pending Xoff, then a pending Xon, then FIFO data
// unless paused. A character already loaded is always finished.
// Assumes: single-entry output register; need_* only set when tx_sel != NONE.
module swfc_tx_arb
    import swfc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fc_sel_e       tx_sel,
    input  logic [DW-1:0] xon1,
    input  logic [DW-1:0] xon2,
    input  logic [DW-1:0] xoff1,
    input  logic [DW-1:0] xoff2,
    input  logic          need_xoff,
    input  logic          need_xon,
    input  logic          paused,
    input  logic          fifo_valid,
    input  logic [DW-1:0] fifo_data,
    output logic          fifo_ready,
    output logic          sh_valid,
    output logic [DW-1:0] sh_data,
    input  logic          sh_ready,
    output logic          xoff_done,
    output logic          xon_done
);

    logic          sv;
    logic [DW-1:0] sd;
    logic          tail_valid;
    logic [DW-1:0] tail_data;

    logic          free, load, tail_set;
    logic [DW-1:0] ld, tail_d, first_off, first_on;

    assign free      = !sv || sh_ready;
    assign first_off = (tx_sel == FC_SET2) ? xoff2 : xoff1;
    assign first_on  = (tx_sel == FC_SET2) ? xon2  : xon1;

    // Priority selection of the next character.
    always_comb begin
        load       = 1'b0;
        ld         = fifo_data;
        xoff_done  = 1'b0;
        xon_done   = 1'b0;
        tail_set   = 1'b0;
        tail_d     = xoff2;
        fifo_ready = 1'b0;
        if (free) begin
            if (tail_valid) begin
                load = 1'b1;
                ld   = tail_data;
            end else if (need_xoff) begin
                load      = 1'b1;
                ld        = first_off;
                xoff_done = 1'b1;
                tail_set  = (tx_sel == FC_BOTH);
                tail_d    = xoff2;
            end else if (need_xon) begin
                load     = 1'b1;
                ld       = first_on;
                xon_done = 1'b1;
                tail_set = (tx_sel == FC_BOTH);
                tail_d   = xon2;
            end else if (!paused) begin
                fifo_ready = 1'b1;
                load       = fifo_valid;
            end
        end
    end

    assign sh_valid = sv;
    assign sh_data  = sd;

    // Output register toward the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv <= 1'b0;
            sd <= '0;
        end else if (load) begin
            sv <= 1'b1;
            sd <= ld;
        end else if (sh_ready) begin
            sv <= 1'b0;
        end
    end

    // Second code of a pair, queued behind the first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_valid <= 1'b0;
            tail_data  <= '0;
        end else if (tail_set) begin
            tail_valid <= 1'b1;
            tail_data  <= tail_d;
        end else if (free && tail_valid) begin
            tail_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/swfc_engine.sv
// Top of the software flow control engine: splits the control field,
// gates special detect, and connects the receive filter, level monitor
// and transmit arbiter.
// Assumes: configuration is static while characters are in flight.
module swfc_engine
    import swfc_pkg::*;
#(
    parameter int DW = 8,
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    cfg_mode,
    input  logic          cfg_spec_en,
    input  logic [DW-1:0] cfg_xon1,
    input  logic [DW-1:0] cfg_xon2,
    input  logic [DW-1:0] cfg_xoff1,
    input  logic [DW-1:0] cfg_xoff2,
    input  logic [LW-1:0] cfg_hi_lvl,
    input  logic [LW-1:0] cfg_lo_lvl,
    input  logic          rxc_valid,
    input  logic [DW-1:0] rxc_data,
    output logic          rxc_ready,
    output logic          rxf_valid,
    output logic [DW-1:0] rxf_data,
    input  logic          rxf_ready,
    input  logic [LW-1:0] rxf_level,
    input  logic          txf_valid,
    input  logic [DW-1:0] txf_data,
    output logic          txf_ready,
    output logic          txs_valid,
    output logic [DW-1:0] txs_data,
    input  logic          txs_ready,
    input  logic          isr_rd,
    output logic          tx_paused,
    output logic          spec_flag
);

    fc_sel_e tx_sel, rx_sel;
    logic    spec_on;
    logic    need_xoff, need_xon, xoff_done, xon_done;

    assign tx_sel  = fc_sel_e'(cfg_mode[3:2]);
    assign rx_sel  = fc_sel_e'(cfg_mode[1:0]);
    assign spec_on = cfg_spec_en && (cfg_mode == 4'b0000);

    swfc_rx_filter #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_sel(rx_sel), .spec_on(spec_on),
        .xon1(cfg_xon1), .xon2(cfg_xon2), .xoff1(cfg_xoff1), .xoff2(cfg_xoff2),
        .in_valid(rxc_valid), .in_data(rxc_data), .in_ready(rxc_ready),
        .out_valid(rxf_valid), .out_data(rxf_data), .out_ready(rxf_ready),
        .flag_clr(isr_rd), .paused(tx_paused), .spec_flag(spec_flag)
    );

    swfc_level_mon #(.LW(LW)) u_lvl (
        .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel), .level(rxf_level),
        .hi_lvl(cfg_hi_lvl), .lo_lvl(cfg_lo_lvl),
        .xoff_done(xoff_done), .xon_done(xon_done),
        .need_xoff(need_xoff), .need_xon(need_xon)
    );

    swfc_tx_arb #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel),
        .xon1(cfg_xon1), .xon2(cfg_xon2), .xoff1(cfg_xoff1), .xoff2(cfg_xoff2),
        .need_xoff(need_xoff), .need_xon(need_xon), .paused(tx_paused),
        .fifo_valid(txf_valid), .fifo_data(txf_data), .fifo_ready(txf_ready),
        .sh_valid(txs_valid), .sh_data(txs_data), .sh_ready(txs_ready),
        .xoff_done(xoff_done), .xon_done(xon_done)
    );

endmodule

// File: rtl/swfc_engine_chk.sv
// Port-level properties of the flow control engine, bound to the top.
module swfc_engine_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    cfg_mode,
    input logic          cfg_spec_en,
    input logic          rxc_valid,
    input logic          rxc_ready,
    input logic          rxf_valid,
    input logic [DW-1:0] rxf_data,
    input logic          rxf_ready,
    input logic          txf_ready,
    input logic          txs_valid,
    input logic [DW-1:0] txs_data,
    input logic          txs_ready,
    input logic          isr_rd,
    input logic          tx_paused,
    input logic          spec_flag
);

    // R12
    rxf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxf_valid && !rxf_ready) |=> (rxf_valid && $stable(rxf_data)));

    // R12
    txs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txs_valid && !txs_ready) |=> (txs_valid && $stable(txs_data)));

    // R5
    pause_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_paused |-> !txf_ready);

    // R4
    rx_off_unpause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode[1:0] == 2'b00) |=> !tx_paused);

    // R10
    spec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spec_flag) |-> ($past(cfg_mode) == 4'b0000 && $past(cfg_spec_en)));

    // R11
    spec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && !(rxc_valid && rxc_ready)) |=> !spec_flag);

endmodule

bind swfc_engine swfc_engine_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_spec_en(cfg_spec_en),
    .rxc_valid(rxc_valid), .rxc_ready(rxc_ready),
    .rxf_valid(rxf_valid), .rxf_data(rxf_data), .rxf_ready(rxf_ready),
    .txf_ready(txf_ready), .txs_valid(txs_valid), .txs_data(txs_data),
    .txs_ready(txs_ready), .isr_rd(isr_rd), .tx_paused(tx_paused),
    .spec_flag(spec_flag)
);

// File: tb/swfc_engine_tb.sv
module swfc_engine_tb;

    localparam int TCLK = 10;
    localparam int DW   = 8;
    localparam int LW   = 6;

    localparam logic [7:0] XON1  = 8'h11;
    localparam logic [7:0] XOFF1 = 8'h13;
    localparam logic [7:0] XON2  = 8'h31;
    localparam logic [7:0] XOFF2 = 8'h33;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    cfg_mode = 4'b0000;
    logic          cfg_spec_en = 1'b0;
    logic [LW-1:0] cfg_hi_lvl = 6'd24;
    logic [LW-1:0] cfg_lo_lvl = 6'd8;
    logic          rxc_valid = 1'b0;
    logic [DW-1:0] rxc_data = '0;
    logic          rxc_ready;
    logic          rxf_valid;
    logic [DW-1:0] rxf_data;
    logic          rxf_ready = 1'b1;
    logic [LW-1:0] rxf_level = '0;
    logic          txf_valid = 1'b0;
    logic [DW-1:0] txf_data = 8'h40;
    logic          txf_ready;
    logic          txs_valid;
    logic [DW-1:0] txs_data;
    logic          txs_ready = 1'b1;
    logic          isr_rd = 1'b0;
    logic          tx_paused;
    logic          spec_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0] rcap [0:4095];
    logic [7:0] tcap [0:4095];
    int rn = 0;
    int tn = 0;
    int tk = 0;

    always #(TCLK/2) clk = ~clk;

    swfc_engine #(.DW(DW), .LW(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_spec_en(cfg_spec_en),
        .cfg_xon1(XON1), .cfg_xon2(XON2), .cfg_xoff1(XOFF1), .cfg_xoff2(XOFF2),
        .cfg_hi_lvl(cfg_hi_lvl), .cfg_lo_lvl(cfg_lo_lvl),
        .rxc_valid(rxc_valid), .rxc_data(rxc_data), .rxc_ready(rxc_ready),
        .rxf_valid(rxf_valid), .rxf_data(rxf_data), .rxf_ready(rxf_ready),
        .rxf_level(rxf_level), .txf_valid(txf_valid), .txf_data(txf_data),
        .txf_ready(txf_ready), .txs_valid(txs_valid), .txs_data(txs_data),
        .txs_ready(txs_ready), .isr_rd(isr_rd), .tx_paused(tx_paused),
        .spec_flag(spec_flag)
    );

    // Capture both output streams and count data taken from the transmit FIFO.
    always @(posedge clk) begin
        if (rst_n) begin
            if (rxf_valid && rxf_ready) begin rcap[rn] = rxf_data; rn = rn + 1; end
            if (txs_valid && txs_ready) begin tcap[tn] = txs_data; tn = tn + 1; end
            if (txf_valid && txf_ready) tk = tk + 1;
        end
    end

    // Transmit FIFO model: head is 0x40 | (count taken mod 64).
    always @(negedge clk) txf_data = 8'h40 | 8'(tk & 63);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] d);
        bit acc = 0;
        rxc_valid = 1'b1;
        rxc_data  = d;
        while (!acc) begin
            #(TCLK/4);
            acc = rxc_ready;
            @(negedge clk);
        end
        rxc_valid = 1'b0;
    endtask

    // Analyse the transmit stream captured since base for tx mode m.
    task automatic check_tx(input int m, input int base, input int c_hi, input int tk0);
        logic [7:0] fl [0:7];
        logic [7:0] ef [0:3];
        logic [7:0] prevd = 8'h00;
        int nf = 0, ne, nd = 0, first_idx = -1;
        bit have = 0, cons_ok = 1;
        if (m == 3) begin ef[0] = XOFF1; ef[1] = XOFF2; ef[2] = XON1; ef[3] = XON2; ne = 4; end
        else if (m == 2) begin ef[0] = XOFF1; ef[1] = XON1; ne = 2; end
        else begin ef[0] = XOFF2; ef[1] = XON2; ne = 2; end
        for (int i = base; i < tn; i++) begin
            if (tcap[i] < 8'h40) begin
                if (nf < 8) fl[nf] = tcap[i];
                if (nf == 0) first_idx = i;
                nf++;
            end else begin
                if (have && tcap[i] != (8'h40 | ((prevd + 8'd1) & 8'h3F))) cons_ok = 0;
                prevd = tcap[i];
                have  = 1;
                nd++;
            end
        end
        // R7: one Xoff burst and one Xon burst, no Xon before the Xoff
        check(nf == ne, "R7 flow char count", nf, ne);
        for (int k = 0; k < ne && k < nf; k++)
            check(fl[k] == ef[k], "R6 flow char code/order", fl[k], ef[k]);
        // R8: Xoff leads ahead of queued data
        check(first_idx >= c_hi && first_idx <= c_hi + 2, "R8 xoff position", first_idx, c_hi + 2);
        check(cons_ok, "R8 data continuity", cons_ok, 1);
        check(nd == tk - tk0, "R8 data count", nd, tk - tk0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(TCLK * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] ex [0:255];
        int base, ne, c_hi, tk0, t0;
        bit exp_p;
        logic [7:0] v, son, soff, hd;

        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1
        check(tx_paused == 0, "R1 tx_paused", tx_paused, 0);
        check(spec_flag == 0, "R1 spec_flag", spec_flag, 0);
        check(rxf_valid == 0, "R1 rxf_valid", rxf_valid, 0);
        check(txs_valid == 0, "R1 txs_valid", txs_valid, 0);

        // R4: all 256 values pass with screening off
        base = rn;
        for (int i = 0; i < 256; i++) send_rx(8'(i));
        idle(3);
        check(rn - base == 256, "R4 count", rn - base, 256);
        for (int i = 0; i < 256; i++)
            check(rcap[base + i] == 8'(i), "R4 data", rcap[base + i], i);
        check(spec_flag == 0, "R9 flag without enable", spec_flag, 0);

        // R9: special detect sweep, flag sticky from the match on
        cfg_spec_en = 1'b1;
        base = rn;
        for (int i = 0; i < 256; i++) begin
            send_rx(8'(i));
            check(spec_flag == (i >= XOFF2), "R9 flag after char", spec_flag, i >= XOFF2);
        end
        idle(3);
        check(rn - base == 256, "R9 all forwarded", rn - base, 256);
        check(rcap[base + XOFF2] == XOFF2, "R9 special byte kept", rcap[base + XOFF2], XOFF2);
        // R11
        idle(5);
        check(spec_flag == 1, "R11 flag held", spec_flag, 1);
        isr_rd = 1'b1; idle(1); isr_rd = 1'b0;
        check(spec_flag == 0, "R11 flag cleared by read", spec_flag, 0);

        // R10: special detect ignored with a nonzero field
        cfg_mode = 4'b0100;
        base = rn;
        send_rx(XOFF2); idle(3);
        check(spec_flag == 0, "R10 tx mode set", spec_flag, 0);
        check(rn - base == 1, "R10 byte forwarded", rn - base, 1);
        cfg_mode = 4'b0001;
        base = rn;
        send_rx(XOFF2); idle(3);
        check(spec_flag == 0, "R10 rx mode set", spec_flag, 0);
        check(tx_paused == 1 && rn == base, "R10 consumed as flow", tx_paused, 1);
        cfg_spec_en = 1'b0;

        // R2: single-set sweeps, set1 upward then set2 downward
        for (int p = 0; p < 2; p++) begin
            cfg_mode = 4'b0000; idle(2);
            check(tx_paused == 0, "R4 pause cleared", tx_paused, 0);
            cfg_mode = (p == 0) ? 4'b0010 : 4'b0001;
            son  = (p == 0) ? XON1 : XON2;
            soff = (p == 0) ? XOFF1 : XOFF2;
            idle(1);
            base = rn; ne = 0; exp_p = 0;
            for (int i = 0; i < 256; i++) begin
                v = (p == 0) ? 8'(i) : 8'(255 - i);
                send_rx(v);
                if (v == soff) exp_p = 1;
                else if (v == son) exp_p = 0;
                else begin ex[ne] = v; ne++; end
                check(tx_paused == exp_p, "R2 pause state", tx_paused, exp_p);
            end
            idle(3);
            check(rn - base == ne, "R2 forwarded count", rn - base, ne);
            for (int k = 0; k < ne; k++)
                check(rcap[base + k] == ex[k], "R2 forwarded data", rcap[base + k], ex[k]);
        end

        // R3: combined-set pairs
        cfg_mode = 4'b0000; idle(2);
        cfg_mode = 4'b0011; idle(1);
        base = rn;
        send_rx(XOFF1); send_rx(XOFF2); idle(3);
        check(tx_paused == 1 && rn == base, "R3 xoff pair pauses", tx_paused, 1);
        send_rx(XON1); send_rx(XON2); idle(3);
        check(tx_paused == 0 && rn == base, "R3 xon pair resumes", tx_paused, 0);
        send_rx(XOFF1); send_rx(8'h41); idle(3);
        check(rn - base == 2, "R3 broken pair count", rn - base, 2);
        check(rcap[base] == XOFF1 && rcap[base + 1] == 8'h41, "R3 broken pair data", rcap[base], XOFF1);
        check(tx_paused == 0, "R3 broken pair no pause", tx_paused, 0);
        base = rn;
        send_rx(XOFF2); idle(3);
        check(rn - base == 1 && rcap[base] == XOFF2, "R3 lone second code", rcap[base], XOFF2);
        base = rn;
        send_rx(XON1); send_rx(XOFF1); send_rx(XOFF2); idle(3);
        check(rn - base == 1 && rcap[base] == XON1, "R3 rejudged newcomer", rcap[base], XON1);
        check(tx_paused == 1, "R3 pause after rejudge", tx_paused, 1);

        // R5: pause stops data toward the shifter
        cfg_mode = 4'b0000; idle(2);
        cfg_mode = 4'b0010;
        txf_valid = 1'b1;
        idle(5);
        send_rx(XOFF1);
        idle(2);
        t0 = tn;
        idle(10);
        check(tn == t0, "R5 no data while paused", tn - t0, 0);
        check(txf_ready == 0, "R5 txf_ready low", txf_ready, 0);
        send_rx(XON1);
        idle(5);
        check(tn > t0, "R5 data resumes", tn - t0, 5);

        // R12: hold under back-pressure on both outputs
        txs_ready = 1'b0; idle(1);
        hd = txs_data; idle(5);
        check(txs_valid == 1 && txs_data == hd, "R12 txs hold", txs_data, hd);
        txs_ready = 1'b1;
        txf_valid = 1'b0; idle(4);
        cfg_mode = 4'b0000;
        rxf_ready = 1'b0;
        send_rx(8'h5A); idle(5);
        check(rxf_valid == 1 && rxf_data == 8'h5A, "R12 rxf hold", rxf_data, 8'h5A);
        rxf_ready = 1'b1; idle(3);

        // R6/R7/R8: level ramps under a continuous data stream
        for (int m = 1; m < 4; m++) begin
            cfg_mode = {2'(m), 2'b00};
            rxf_level = '0;
            idle(2);
            base = tn; tk0 = tk; c_hi = 0;
            txf_valid = 1'b1;
            idle(4);
            for (int l = 0; l < 64; l++) begin
                rxf_level = (l < 32) ? 6'(l) : 6'(63 - l);
                if (l == 24) c_hi = tn;
                @(negedge clk);
            end
            idle(4);
            txf_valid = 1'b0;
            idle(6);
            check_tx(m, base, c_hi, tk0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule